// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Assembler

This block sits between program memory and an instruction decoder. It pulls a byte stream from a byte-wide fetch port with a valid/ready handshake. It groups the bytes into complete instructions of one, two or three bytes. The first byte of every instruction is the opcode. A small class code arrives alongside that byte and selects how many operand bytes follow: none, one 8-bit operand, or a 16-bit operand made of two bytes.

When the last byte of an instruction has been taken, the block raises a one-cycle instruction strobe. The strobe comes with the opcode, an 8-bit operand field and a 16-bit operand field. A 16-bit operand is built from two successive bytes, and the low byte arrives first. A 16-bit program counter points at the next byte to fetch and advances once for every byte accepted. The block does not decode the opcode further and takes no part in execution or branching.

Top module: `ifa_top`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears fb_addr to 0 and ins_valid to 0, clears the output fields to 0, and returns the block to waiting for an opcode. fb_ready is low while rst is high.
- R2: fb_ready is high whenever rst is low. A byte is accepted at a rising edge where both fb_valid and fb_ready are high.
- R3: fb_addr is 16 bits wide. It rises by exactly one after each accepted byte and holds its value in every other cycle.
- R4: fb_cls is sampled only together with an opcode byte. Its codes are: 2'b00 = no operand, 2'b01 = one operand byte, 2'b10 = two operand bytes, 2'b11 = reserved, treated as no operand. On operand bytes, fb_cls has no effect.
- R5: A single-byte instruction produces ins_valid in the cycle after its acceptance edge, with ins_opcode set to that byte and both ins_imm8 and ins_imm16 equal to 0.
- R6: A two-byte instruction produces ins_imm8 equal to the operand byte and ins_imm16 equal to {8'h00, operand byte}.
- R7: In a three-byte instruction, the second byte is the low half and the third byte is the high half. The result is ins_imm16 = {third, second} and ins_imm8 = second.
- R8: ins_valid is high for exactly one cycle per instruction: the cycle after the edge that accepts the final byte. The output fields hold their values until the next instruction completes.
- R9: While fb_valid is low, nothing advances and no byte is lost. An instruction may stall for any number of cycles between any two of its bytes.
- R10: A reset in the middle of an instruction discards the partial bytes. The next accepted byte is treated as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fb_valid | input | 1 | Fetch byte present |
| fb_data | input | 8 | Fetched byte |
| fb_cls | input | 2 | Operand-length class, meaningful with an opcode byte |
| fb_ready | output | 1 | Block can take a byte |
| fb_addr | output | 16 | Program counter: address of the next byte to fetch |
| ins_valid | output | 1 | One-cycle strobe for a complete instruction |
| ins_opcode | output | 8 | Opcode of the completed instruction |
| ins_imm8 | output | 8 | First operand byte, or 0 |
| ins_imm16 | output | 16 | Assembled 16-bit operand (zero-extended for one byte) |

## Verification
The hardest case to reach is a three-byte instruction whose operand bytes are split by idle cycles. The hard part is the gap between the low and the high half, which comes while a new class code is being driven on the unused fb_cls lines. In that case the held low byte must survive, and the class must not be sampled again. The stimulus reaches it in two ways. Directed sequences insert gaps before and between operand bytes. A long random phase then drops fb_valid at random and drives random classes and data on every cycle. A mid-instruction reset is also forced, to show that partial bytes are discarded.

// File: rtl/ifa_pkg.sv
package ifa_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_OPC = 2'd0,
        ST_LO  = 2'd1,
        ST_HI  = 2'd2
    } seq_st_e;

    typedef struct packed {
        seq_st_e            st;
        logic [1:0]         nopnd;
        logic [BYTE_W-1:0]  opc;
        logic [BYTE_W-1:0]  lo;
        logic               vld;
        logic [BYTE_W-1:0]  out_opc;
        logic [BYTE_W-1:0]  out_i8;
        logic [2*BYTE_W-1:0] out_i16;
    } seq_s;
endpackage

// File: rtl/ifa_len_lut.sv
module ifa_len_lut #(
    parameter int CLS_W = 2
) (
    input  logic [CLS_W-1:0] cls,
    output logic [1:0]       nopnd
);
    always_comb begin
        if (cls == CLS_W'(1))      nopnd = 2'd1;
        else if (cls == CLS_W'(2)) nopnd = 2'd2;
        else                       nopnd = 2'd0;
    end
endmodule

// File: rtl/ifa_pc.sv
module ifa_pc #(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    output logic [PC_W-1:0] pc
);
    logic [PC_W-1:0] pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        if (step) pc_d = pc_q + PC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign pc = pc_q;
endmodule

// File: rtl/ifa_pack.sv
module ifa_pack #(
    parameter int BW = 8
) (
    input  logic [1:0]    len,
    input  logic [BW-1:0] lo,
    input  logic [BW-1:0] hi,
    output logic [BW-1:0] i8,
    output logic [2*BW-1:0] i16
);
    always_comb begin
        i8  = '0;
        i16 = '0;
        if (len != 2'd0) begin
            i8  = lo;
            i16 = {{BW{1'b0}}, lo};
        end
        if (len == 2'd2) i16 = {hi, lo};
    end
endmodule

// File: rtl/ifa_top.sv
module ifa_top
    import ifa_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int CLS_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fb_valid,
    input  logic [BYTE_W-1:0]    fb_data,
    input  logic [CLS_W-1:0]     fb_cls,
    output logic                 fb_ready,
    output logic [PC_W-1:0]      fb_addr,
    output logic                 ins_valid,
    output logic [BYTE_W-1:0]    ins_opcode,
    output logic [BYTE_W-1:0]    ins_imm8,
    output logic [2*BYTE_W-1:0]  ins_imm16
);
    seq_s q, d;
    logic                acc;
    logic [1:0]          lut_n;
    logic [1:0]          pk_len;
    logic [BYTE_W-1:0]   pk_lo;
    logic [BYTE_W-1:0]   pk_i8;
    logic [2*BYTE_W-1:0] pk_i16;
    logic                at_opc;

    assign fb_ready = ~rst;
    assign acc      = fb_valid & fb_ready;
    assign at_opc   = (q.st == ST_OPC);

    ifa_len_lut #(.CLS_W(CLS_W)) u_lut (
        .cls   (fb_cls),
        .nopnd (lut_n)
    );

    ifa_pc #(.PC_W(PC_W)) u_pc (
        .clk  (clk),
        .rst  (rst),
        .step (acc),
        .pc   (fb_addr)
    );

    assign pk_len = at_opc ? 2'd0 : q.nopnd;
    assign pk_lo  = (q.st == ST_LO) ? fb_data : q.lo;

    ifa_pack #(.BW(BYTE_W)) u_pack (
        .len (pk_len),
        .lo  (pk_lo),
        .hi  (fb_data),
        .i8  (pk_i8),
        .i16 (pk_i16)
    );

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (acc) begin
            case (q.st)
                ST_OPC: begin
                    d.opc   = fb_data;
                    d.nopnd = lut_n;
                    if (lut_n == 2'd0) begin
                        d.vld     = 1'b1;
                        d.out_opc = fb_data;
                        d.out_i8  = pk_i8;
                        d.out_i16 = pk_i16;
                    end else begin
                        d.st = ST_LO;
                    end
                end
                ST_LO: begin
                    d.lo = fb_data;
                    if (q.nopnd == 2'd1) begin
                        d.vld     = 1'b1;
                        d.out_opc = q.opc;
                        d.out_i8  = pk_i8;
                        d.out_i16 = pk_i16;
                        d.st      = ST_OPC;
                    end else begin
                        d.st = ST_HI;
                    end
                end
                ST_HI: begin
                    d.vld     = 1'b1;
                    d.out_opc = q.opc;
                    d.out_i8  = pk_i8;
                    d.out_i16 = pk_i16;
                    d.st      = ST_OPC;
                end
                default: d.st = ST_OPC;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign ins_valid  = q.vld;
    assign ins_opcode = q.out_opc;
    assign ins_imm8   = q.out_i8;
    assign ins_imm16  = q.out_i16;
endmodule

// File: rtl/ifa_chk.sv
module ifa_chk #(
    parameter int PC_W  = 16,
    parameter int CLS_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             fb_valid,
    input logic [7:0]       fb_data,
    input logic [CLS_W-1:0] fb_cls,
    input logic             fb_ready,
    input logic [PC_W-1:0]  fb_addr,
    input logic             ins_valid,
    input logic [7:0]       ins_opcode,
    input logic [15:0]      ins_imm16,
    input logic             at_opc
);
    // R1
    rdy_in_rst_chk: assert property (@(posedge clk) rst |-> !fb_ready);

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (fb_valid && fb_ready) |=> fb_addr == PC_W'($past(fb_addr) + PC_W'(1)));

    // R3
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(fb_valid && fb_ready) |=> $stable(fb_addr));

    // R8
    vld_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ins_valid |-> $past(fb_valid && fb_ready));

    // R9
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !fb_valid |=> !ins_valid);

    // R5
    one_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (fb_valid && fb_ready && at_opc && (fb_cls == CLS_W'(0) || fb_cls == CLS_W'(3)))
        |=> ins_valid && ins_opcode == $past(fb_data) && ins_imm16 == 16'h0);
endmodule

bind ifa_top ifa_chk #(.PC_W(PC_W), .CLS_W(CLS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fb_valid   (fb_valid),
    .fb_data    (fb_data),
    .fb_cls     (fb_cls),
    .fb_ready   (fb_ready),
    .fb_addr    (fb_addr),
    .ins_valid  (ins_valid),
    .ins_opcode (ins_opcode),
    .ins_imm16  (ins_imm16),
    .at_opc     (at_opc)
);

// File: tb/ifa_top_tb.sv
module ifa_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fb_valid = 1'b0;
    logic [7:0]  fb_data = 8'h00;
    logic [1:0]  fb_cls = 2'b00;
    logic        fb_ready;
    logic [15:0] fb_addr;
    logic        ins_valid;
    logic [7:0]  ins_opcode;
    logic [7:0]  ins_imm8;
    logic [15:0] ins_imm16;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int         m_pc = 0;
    int         m_need = -1;
    logic [7:0] m_opc = 8'h00;
    logic [7:0] m_q[$];
    logic       e_vld = 1'b0;
    logic [7:0] e_opc = 8'h00;
    logic [7:0] e_i8 = 8'h00;
    logic [15:0] e_i16 = 16'h0000;
    string      e_tag = "R1";

    always #10 clk = ~clk;

    ifa_top u_dut (
        .clk(clk), .rst(rst), .fb_valid(fb_valid), .fb_data(fb_data),
        .fb_cls(fb_cls), .fb_ready(fb_ready), .fb_addr(fb_addr),
        .ins_valid(ins_valid), .ins_opcode(ins_opcode),
        .ins_imm8(ins_imm8), .ins_imm16(ins_imm16)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_instr();
        e_vld = 1'b1;
        e_opc = m_opc;
        e_i8  = (m_q.size() >= 1) ? m_q[0] : 8'h00;
        if (m_q.size() == 2)      e_i16 = {m_q[1], m_q[0]};
        else if (m_q.size() == 1) e_i16 = {8'h00, m_q[0]};
        else                      e_i16 = 16'h0000;
        e_tag = (m_q.size() == 2) ? "R7" : (m_q.size() == 1) ? "R6" : "R5";
        m_need = -1;
        m_q.delete();
    endtask

    // reference model: applies the inputs about to be sampled at the next edge
    task automatic model_step();
        if (rst) begin
            m_pc = 0; m_need = -1; m_q.delete();
            e_vld = 0; e_opc = 0; e_i8 = 0; e_i16 = 0; e_tag = "R1";
        end else begin
            e_vld = 1'b0;
            if (fb_valid) begin
                m_pc = (m_pc + 1) % 65536;
                if (m_need < 0) begin
                    m_opc  = fb_data;
                    m_need = (fb_cls == 2'b01) ? 1 : (fb_cls == 2'b10) ? 2 : 0;
                    if (m_need == 0) finish_instr();
                end else begin
                    m_q.push_back(fb_data);
                    if (m_q.size() == m_need) finish_instr();
                end
            end
        end
    endtask

    task automatic compare_all();
        chk(rst ? "R1" : "R2", {31'd0, fb_ready}, {31'd0, ~rst}, "fb_ready");
        chk("R3", {16'd0, fb_addr}, m_pc, "fb_addr");
        chk("R8", {31'd0, ins_valid}, {31'd0, e_vld}, "ins_valid");
        chk(e_tag, {24'd0, ins_opcode}, {24'd0, e_opc}, "ins_opcode");
        chk(e_tag, {24'd0, ins_imm8}, {24'd0, e_i8}, "ins_imm8");
        chk(e_tag, {16'd0, ins_imm16}, {16'd0, e_i16}, "ins_imm16");
    endtask

    task automatic cyc(input logic v, input logic [7:0] dat, input logic [1:0] c, input logic r);
        @(negedge clk);
        compare_all();
        rst = r; fb_valid = v; fb_data = dat; fb_cls = c;
        model_step();
    endtask

    initial begin
        model_step();
        // R1: reset state
        repeat (3) cyc(1'b1, 8'hAA, 2'b10, 1'b1);
        cyc(1'b0, 8'h00, 2'b00, 1'b0);
        // R5: single-byte, back to back
        cyc(1'b1, 8'h11, 2'b00, 1'b0);
        cyc(1'b1, 8'h12, 2'b00, 1'b0);
        // R4: reserved class acts as no operand
        cyc(1'b1, 8'h13, 2'b11, 1'b0);
        // R6: two-byte, class on operand byte ignored
        cyc(1'b1, 8'h24, 2'b01, 1'b0);
        cyc(1'b1, 8'h5A, 2'b10, 1'b0);
        // R7: three-byte, low byte then high byte
        cyc(1'b1, 8'h90, 2'b10, 1'b0);
        cyc(1'b1, 8'h34, 2'b01, 1'b0);
        cyc(1'b1, 8'h12, 2'b00, 1'b0);
        // R9: three-byte with stalls between every byte
        cyc(1'b1, 8'h91, 2'b10, 1'b0);
        repeat (3) cyc(1'b0, 8'hFF, 2'b00, 1'b0);
        cyc(1'b1, 8'hCD, 2'b11, 1'b0);
        repeat (4) cyc(1'b0, 8'hEE, 2'b01, 1'b0);
        cyc(1'b1, 8'hAB, 2'b10, 1'b0);
        cyc(1'b0, 8'h00, 2'b00, 1'b0);
        // R10: reset mid-instruction, next byte is an opcode
        cyc(1'b1, 8'h92, 2'b10, 1'b0);
        cyc(1'b1, 8'h77, 2'b00, 1'b0);
        cyc(1'b0, 8'h00, 2'b00, 1'b1);
        cyc(1'b1, 8'h15, 2'b00, 1'b0);
        cyc(1'b0, 8'h00, 2'b00, 1'b0);
        // R4/R8/R9: random traffic with random gaps
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 3) != 0, 8'($urandom), 2'($urandom), 1'b0);
        end
        cyc(1'b0, 8'h00, 2'b00, 1'b0);
        cyc(1'b0, 8'h00, 2'b00, 1'b0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule